// File: doc/BRIEF.md
# Bus Transfer Status Register

This block keeps the completion status of a host-bus interface. The bus master engine pulses an end strobe for each transaction it starts, along with the number of beats moved and the cause of termination. From these the block keeps three things: a full-transfer flag that is rewritten at every end, and sticky timeout and retry flags. When termination interrupts are enabled, either sticky cause raises an interrupt. Generic abort detectors feed further sticky bits.

On the target side, the block watches host writes to the receive register. It raises a sticky "path drained" flag when the core has emptied the host-to-core path and the lock enable is on. The trigger is either a non-exclusive write finishing, or the lock being released after an exclusive write has completed. While the drained flag is set, every new host write to the receive register gets a retry. Once it is cleared, retries follow the normal path-full status.

The core reads the status word combinationally and clears flags by writing ones (write-one-to-clear). A software reset clears all status state.

Top module: `bus_xfer_status`

## Requirements
- R1: At each master end strobe, status bit 0 becomes 1 if the transferred beat count equals the burst length and the count enable is 1, and 0 otherwise. It holds between ends and ignores core writes.
- R2: While the count enable input is 0, status bit 0 reads 0.
- R3: A master end with the timeout cause sets bit 1. A master end with the retry cause sets bit 2. Both stay set until cleared.
- R4: The interrupt output is 1 exactly when the termination-interrupt enable is 1 and bit 1 or bit 2 is set.
- R5: Bit 3 (drained) sets when a non-exclusive receive-register write finishes while the lock enable is 1 and both receive-request flags are 0. If any of these conditions fails, it does not set.
- R6: An exclusive write does not set bit 3 by itself. A lock release that follows a completed exclusive write sets bit 3 under the same conditions as R5.
- R7: Master transaction ends, reads included, never set bit 3.
- R8: While bit 3 is 1, the retry output follows the write request. While bit 3 is 0, it equals write request AND path full.
- R9: Writing 1 to bit 1, 2 or 3, or to an abort bit, clears it on the next cycle. Writing 0 leaves it unchanged.
- R10: If a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: Both the asynchronous reset and the software reset clear all status bits, including bit 3.
- R12: Bits above the abort bits always read 0, whatever is written to them.
- R13: Abort input i sets sticky bit 4+i, which clears only by a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous software reset of all status |
| cnt_en_i | input | 1 | Master beat counter enable |
| term_irq_en_i | input | 1 | Termination interrupt enable |
| lock_en_i | input | 1 | Receive-buffer lock enable |
| burst_len_i | input | CNT_W | Programmed burst length |
| mst_end_i | input | 1 | Master transaction end strobe |
| mst_beats_i | input | CNT_W | Beats transferred, valid with end |
| mst_tmo_i | input | 1 | End caused by grant loss after latency expiry |
| mst_rty_i | input | 1 | End caused by target retry |
| abort_i | input | NUM_ABORT | Sticky abort event strobes |
| tgt_wr_done_i | input | 1 | Host write to receive register terminated or completed |
| tgt_wr_excl_i | input | 1 | That write was exclusive (locked) |
| lock_release_i | input | 1 | Bus lock released |
| slv_rreq_i | input | 1 | Slave receive request flag |
| mst_rreq_i | input | 1 | Master receive request flag |
| tgt_wr_req_i | input | 1 | New host write to receive register |
| path_full_i | input | 1 | Normal data-path full status |
| reg_we_i | input | 1 | Core register write strobe |
| reg_wdata_i | input | DATA_W | Core write data |
| reg_rdata_o | output | DATA_W | Status word |
| irq_o | output | 1 | Termination interrupt request |
| tgt_retry_o | output | 1 | Retry/disconnect for target engine |

## Verification
The assertions assume that strobes are clean single-cycle pulses on a synchronous clock. They also assume the cause flags are meaningful only while the end strobe is high, and that beat counts and burst lengths fit in CNT_W. The bench drives every strobe for exactly one cycle, at the falling edge. It raises the cause flags only together with an end strobe. It orders the exclusive write before its lock release, and holds the control enables steady around each event it checks.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int unsigned OK_BIT   = 0;
  localparam int unsigned TMO_BIT  = 1;
  localparam int unsigned RTY_BIT  = 2;
  localparam int unsigned DRN_BIT  = 3;
  localparam int unsigned ABT_BASE = 4;
  // sticky vector order
  localparam int unsigned S_TMO = 0;
  localparam int unsigned S_RTY = 1;
  localparam int unsigned S_DRN = 2;
  localparam int unsigned S_ABT = 3;
endpackage

// File: rtl/bxs_w1c_bits.sv
module bxs_w1c_bits #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_q <= 1'b0;
      else if (sclr_i)    q_q <= 1'b0;
      else if (set_i[i])  q_q <= 1'b1;   // set beats clear
      else if (clr_i[i])  q_q <= 1'b0;
    end
    assign q_o[i] = q_q;

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || sclr_i)
      set_i[i] |=> q_o[i]);
    assert_w1c_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !sclr_i && q_o[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/bxs_mst_track.sv
module bxs_mst_track #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclr_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] burst_len_i,
  input  logic             mst_end_i,
  input  logic [CNT_W-1:0] mst_beats_i,
  input  logic             mst_tmo_i,
  input  logic             mst_rty_i,
  output logic             ok_o,
  output logic             tmo_set_o,
  output logic             rty_set_o
);
  logic ok_q;
  logic full_xfer;

  assign full_xfer = cnt_en_i && (mst_beats_i == burst_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ok_q <= 1'b0;
    else if (sclr_i)    ok_q <= 1'b0;
    else if (mst_end_i) ok_q <= full_xfer;  // rewritten every end
  end

  assign ok_o      = ok_q;
  assign tmo_set_o = mst_end_i && mst_tmo_i;
  assign rty_set_o = mst_end_i && mst_rty_i;

  assert_ok_short_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || sclr_i)
    (mst_end_i && (mst_beats_i != burst_len_i)) |=> !ok_o);
  assert_ok_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || sclr_i)
    !mst_end_i |=> $stable(ok_o));
endmodule

// File: rtl/bxs_drain_track.sv
module bxs_drain_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclr_i,
  input  logic lock_en_i,
  input  logic tgt_wr_done_i,
  input  logic tgt_wr_excl_i,
  input  logic lock_release_i,
  input  logic slv_rreq_i,
  input  logic mst_rreq_i,
  input  logic tgt_wr_req_i,
  input  logic path_full_i,
  input  logic drn_q_i,
  output logic drn_set_o,
  output logic tgt_retry_o
);
  logic excl_pend_q;
  logic path_empty;
  logic plain_done;
  logic locked_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              excl_pend_q <= 1'b0;
    else if (sclr_i)                          excl_pend_q <= 1'b0;
    else if (tgt_wr_done_i && tgt_wr_excl_i)  excl_pend_q <= 1'b1;
    else if (lock_release_i)                  excl_pend_q <= 1'b0;
  end

  assign path_empty  = lock_en_i && !slv_rreq_i && !mst_rreq_i;
  assign plain_done  = tgt_wr_done_i && !tgt_wr_excl_i;
  assign locked_done = lock_release_i && excl_pend_q;
  assign drn_set_o   = path_empty && (plain_done || locked_done);

  always_comb begin
    if (drn_q_i) tgt_retry_o = tgt_wr_req_i;
    else         tgt_retry_o = tgt_wr_req_i && path_full_i;
  end

  assert_excl_no_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_wr_done_i && tgt_wr_excl_i && !lock_release_i) |-> !drn_set_o);
  assert_drn_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_en_i || slv_rreq_i || mst_rreq_i) |-> !drn_set_o);
endmodule

// File: rtl/bus_xfer_status.sv
module bus_xfer_status
  import bxs_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned NUM_ABORT = 2,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 cnt_en_i,
  input  logic                 term_irq_en_i,
  input  logic                 lock_en_i,
  input  logic [CNT_W-1:0]     burst_len_i,
  input  logic                 mst_end_i,
  input  logic [CNT_W-1:0]     mst_beats_i,
  input  logic                 mst_tmo_i,
  input  logic                 mst_rty_i,
  input  logic [NUM_ABORT-1:0] abort_i,
  input  logic                 tgt_wr_done_i,
  input  logic                 tgt_wr_excl_i,
  input  logic                 lock_release_i,
  input  logic                 slv_rreq_i,
  input  logic                 mst_rreq_i,
  input  logic                 tgt_wr_req_i,
  input  logic                 path_full_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic                 tgt_retry_o
);
  localparam int unsigned NSTK = S_ABT + NUM_ABORT;
  localparam int unsigned USED = ABT_BASE + NUM_ABORT;

  logic            ok;
  logic            tmo_set, rty_set, drn_set;
  logic [NSTK-1:0] stk_set, stk_clr, stk_q;
  logic            unused_wdata;

  bxs_mst_track #(.CNT_W(CNT_W)) i_mst (
    .clk_i, .rst_ni, .sclr_i(soft_rst_i), .cnt_en_i, .burst_len_i,
    .mst_end_i, .mst_beats_i, .mst_tmo_i, .mst_rty_i,
    .ok_o(ok), .tmo_set_o(tmo_set), .rty_set_o(rty_set)
  );

  bxs_drain_track i_drn (
    .clk_i, .rst_ni, .sclr_i(soft_rst_i), .lock_en_i, .tgt_wr_done_i,
    .tgt_wr_excl_i, .lock_release_i, .slv_rreq_i, .mst_rreq_i,
    .tgt_wr_req_i, .path_full_i, .drn_q_i(stk_q[S_DRN]),
    .drn_set_o(drn_set), .tgt_retry_o
  );

  always_comb begin
    stk_set        = '0;
    stk_set[S_TMO] = tmo_set;
    stk_set[S_RTY] = rty_set;
    stk_set[S_DRN] = drn_set;
    stk_clr        = '0;
    stk_clr[S_TMO] = reg_we_i && reg_wdata_i[TMO_BIT];
    stk_clr[S_RTY] = reg_we_i && reg_wdata_i[RTY_BIT];
    stk_clr[S_DRN] = reg_we_i && reg_wdata_i[DRN_BIT];
    for (int i = 0; i < int'(NUM_ABORT); i++) begin
      stk_set[S_ABT+i] = abort_i[i];
      stk_clr[S_ABT+i] = reg_we_i && reg_wdata_i[ABT_BASE+i];
    end
  end

  bxs_w1c_bits #(.W(NSTK)) i_stk (
    .clk_i, .rst_ni, .sclr_i(soft_rst_i),
    .set_i(stk_set), .clr_i(stk_clr), .q_o(stk_q)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[OK_BIT]  = ok && cnt_en_i;
    reg_rdata_o[TMO_BIT] = stk_q[S_TMO];
    reg_rdata_o[RTY_BIT] = stk_q[S_RTY];
    reg_rdata_o[DRN_BIT] = stk_q[S_DRN];
    for (int i = 0; i < int'(NUM_ABORT); i++)
      reg_rdata_o[ABT_BASE+i] = stk_q[S_ABT+i];
  end

  assign irq_o = term_irq_en_i && (stk_q[S_TMO] || stk_q[S_RTY]);

  assign unused_wdata = ^{reg_wdata_i[OK_BIT], reg_wdata_i[DATA_W-1:USED]};

  assert_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_irq_en_i && (reg_rdata_o[TMO_BIT] || reg_rdata_o[RTY_BIT])) |-> irq_o);
  assert_retry_drained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[DRN_BIT] && tgt_wr_req_i) |-> tgt_retry_o);
  assert_ok_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |-> !reg_rdata_o[OK_BIT]);
  assert_reserved_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:USED] == '0);
  assert_soft_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !reg_rdata_o[DRN_BIT]);
  assert_mst_no_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (mst_end_i && !tgt_wr_done_i && !lock_release_i && !reg_rdata_o[DRN_BIT]
     && !(reg_we_i && reg_wdata_i[DRN_BIT])) |=> !reg_rdata_o[DRN_BIT]);
endmodule

// File: tb/test_bus_xfer_status.sv
module test_bus_xfer_status;
  localparam int CNT_W = 8, NA = 2, DW = 16;

  logic clk = 0, rst_ni = 0;
  logic soft_rst, cnt_en, irq_en, lock_en, mst_end, tmo, rty;
  logic wr_done, wr_excl, lock_rel, srq, mrq, wr_req, pfull, we;
  logic [CNT_W-1:0] blen, beats;
  logic [NA-1:0] abort;
  logic [DW-1:0] wdata, rdata;
  logic irq, retry;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_xfer_status #(.CNT_W(CNT_W), .NUM_ABORT(NA), .DATA_W(DW)) i_bus_xfer_status (
    .clk_i(clk), .rst_ni, .soft_rst_i(soft_rst), .cnt_en_i(cnt_en),
    .term_irq_en_i(irq_en), .lock_en_i(lock_en), .burst_len_i(blen),
    .mst_end_i(mst_end), .mst_beats_i(beats), .mst_tmo_i(tmo), .mst_rty_i(rty),
    .abort_i(abort), .tgt_wr_done_i(wr_done), .tgt_wr_excl_i(wr_excl),
    .lock_release_i(lock_rel), .slv_rreq_i(srq), .mst_rreq_i(mrq),
    .tgt_wr_req_i(wr_req), .path_full_i(pfull), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tgt_retry_o(retry)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    soft_rst = 0; mst_end = 0; tmo = 0; rty = 0; abort = '0; wr_done = 0;
    wr_excl = 0; lock_rel = 0; wr_req = 0; we = 0; wdata = '0; beats = '0;
  endtask

  task automatic step(); @(negedge clk); idle(); endtask

  task automatic w1c(logic [DW-1:0] v); we = 1; wdata = v; step(); endtask

  task automatic t_reset();
    check("R11 reset rdata", rdata, 0);
    check("R4 reset irq", irq, 0);
    check("R8 reset retry", retry, 0);
  endtask

  task automatic t_full_xfer();
    cnt_en = 1; blen = 8'd4;
    mst_end = 1; beats = 8'd4; step();
    check("R1 full burst", rdata[0], 1);
    step();
    check("R1 hold", rdata[0], 1);
    w1c(16'h0001);
    check("R1 write ignored", rdata[0], 1);
    mst_end = 1; beats = 8'd3; step();
    check("R1 short burst", rdata[0], 0);
    mst_end = 1; beats = 8'd4; step();
    cnt_en = 0; #1;
    check("R2 count disabled", rdata[0], 0);
    mst_end = 1; beats = 8'd4; step();
    cnt_en = 1; #1;
    check("R2 end while disabled stores 0", rdata[0], 0);
  endtask

  task automatic t_term();
    irq_en = 0;
    mst_end = 1; beats = 8'd1; tmo = 1; step();
    check("R3 timeout set", rdata[1], 1);
    check("R4 irq off when disabled", irq, 0);
    irq_en = 1; #1;
    check("R4 irq on", irq, 1);
    w1c(16'h0000);
    check("R9 write 0 keeps", rdata[1], 1);
    w1c(16'h0002);
    check("R9 clear timeout", rdata[1], 0);
    check("R4 irq drops", irq, 0);
    mst_end = 1; rty = 1; step();
    check("R3 retry set", rdata[2], 1);
    check("R4 irq from retry", irq, 1);
    w1c(16'h0004);
    check("R9 clear retry", rdata[2], 0);
    irq_en = 0;
  endtask

  task automatic t_set_wins();
    mst_end = 1; tmo = 1; we = 1; wdata = 16'h0002; step();
    check("R10 set beats clear", rdata[1], 1);
    w1c(16'h0002);
    check("R10 cleared after", rdata[1], 0);
  endtask

  task automatic t_drain_plain();
    lock_en = 0; srq = 0; mrq = 0;
    wr_done = 1; step();
    check("R5 no set without lock enable", rdata[3], 0);
    lock_en = 1; srq = 1;
    wr_done = 1; step();
    check("R5 no set with slave req", rdata[3], 0);
    srq = 0; mrq = 1;
    wr_done = 1; step();
    check("R5 no set with master req", rdata[3], 0);
    mrq = 0; pfull = 0;
    wr_req = 1; #1;
    check("R8 retry normal path", retry, 0);
    pfull = 1; #1;
    check("R8 retry path full", retry, 1);
    pfull = 0;
    wr_done = 1; step();
    check("R5 drained set", rdata[3], 1);
    wr_req = 1; #1;
    check("R8 retry while drained", retry, 1);
    wr_req = 0; #1;
    check("R8 no retry without request", retry, 0);
    w1c(16'h0000);
    check("R9 drained kept on 0", rdata[3], 1);
    w1c(16'h0008);
    check("R9 drained cleared", rdata[3], 0);
    w1c(16'h0008);
    check("R9 clear when unset no effect", rdata[3], 0);
    wr_req = 1; #1;
    check("R8 normal after clear", retry, 0);
  endtask

  task automatic t_drain_excl();
    wr_done = 1; wr_excl = 1; step();
    check("R6 exclusive write alone", rdata[3], 0);
    step();
    lock_rel = 1; step();
    check("R6 lock release sets", rdata[3], 1);
    w1c(16'h0008);
    lock_rel = 1; step();
    check("R6 release without exclusive write", rdata[3], 0);
  endtask

  task automatic t_mst_read();
    mst_end = 1; beats = 8'd4; step();
    mst_end = 1; beats = 8'd2; rty = 1; step();
    check("R7 master end no drain", rdata[3], 0);
    w1c(16'h0004);
  endtask

  task automatic t_abort();
    abort = 2'b10; step();
    check("R13 abort1 set", rdata[5:4], 2'b10);
    step();
    check("R13 abort sticky", rdata[5:4], 2'b10);
    abort = 2'b01; step();
    w1c(16'h0020);
    check("R13 abort1 cleared", rdata[5:4], 2'b01);
    w1c(16'h0010);
  endtask

  task automatic t_reserved();
    mst_end = 1; beats = 8'd4; tmo = 1; step();
    w1c(16'hFFC0);
    check("R12 reserved zero", rdata[15:6], 0);
    check("R12 other bits untouched", rdata[5:0], 6'b000011);
    w1c(16'hFFFF);
    check("R12 all ones write", rdata, 16'h0001);
  endtask

  task automatic t_soft();
    wr_done = 1; step();
    mst_end = 1; tmo = 1; abort = 2'b11; step();
    check("R11 preset", rdata[5:1], 5'b11101);
    soft_rst = 1; step();
    check("R11 soft reset clears", rdata, 0);
    check("R11 soft reset irq", irq, 0);
  endtask

  initial begin
    idle(); cnt_en = 0; irq_en = 0; lock_en = 0; blen = '0;
    srq = 0; mrq = 0; pfull = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step();
    t_reset();
    t_full_xfer();
    t_term();
    t_set_wins();
    t_drain_plain();
    step();
    t_drain_excl();
    t_mst_read();
    t_abort();
    t_reserved();
    t_soft();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule